// File: doc/BRIEF.md
# EEPROM Shadow Cache with Checksum Validation

This block sits between the consumers of configuration words and a serial EEPROM master. It keeps a local copy of all 64 sixteen-bit EEPROM words. A lookup is answered from that copy whenever the copy carries a valid signature. When the copy is not valid, the block first reloads the whole image through the master. It then checks the image two ways: the additive 16-bit checksum must hit a fixed target, and a masked signature field in word 0 must match a fixed pattern.

The block can also repair the stored checksum. On request it reads words 0 to 62 from the EEPROM, computes the balancing value and writes it into word 63. Any write to the EEPROM marks the local copy stale, so the next lookup reloads the image lazily.

The master is treated as an ideal port. The request is held with a stable address until the master returns a one-cycle acknowledge, and read data is valid with that acknowledge. Only one operation runs at a time.

Top module: `eeshadow_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and `mem_req`, `lk_done`, `upd_done`, `sum_bad` and `sig_bad` are 0. The local copy starts invalid, so the first in-range lookup triggers a load.
- R2: A load issues exactly 64 read requests, one per word, at addresses 0,1,...,63 in ascending order. Each request stays asserted, with a stable address, until `mem_ack`.
- R3: The image passes the checksum only when the sum of all 64 words, taken modulo 2^16, equals 0xBABA. On failure:
  - `sum_bad` becomes 1 and `sig_bad` becomes 0.
  - The lookup answers with `lk_valid`=0 and `lk_data`=0.
  - The signature field of the cached word 0 is cleared, so the next lookup loads the image again.
- R4: When the checksum passes but (word0 & 0xC000) != 0x4000, `sig_bad` becomes 1, `sum_bad` becomes 0, and the lookup answers with `lk_valid`=0 and `lk_data`=0. After a load that passes both tests, both flags are 0.
- R5: While the local copy holds a valid signature, a lookup returns the cached word with `lk_valid`=1 and issues no EEPROM request, even if the EEPROM content has changed since the load.
- R6: A lookup with index 64 or higher answers with `lk_valid`=0 and `lk_data`=0 and issues no EEPROM request.
- R7: A checksum update issues 63 reads (words 0 to 62) followed by one write to address 63. The written data is (0xBABA - sum of words 0..62) mod 2^16.
- R8: An EEPROM write clears the cached signature, so the next in-range lookup performs a full 64-word load.
- R9: `ready` is 1 only while no operation is running. A request is taken only at a clock edge where `ready` is 1. If lookup and update requests are both present at such an edge, the lookup is taken first and the update waits until `ready` returns.
- R10: Each finished lookup gives a one-cycle `lk_done` pulse, and each finished update gives a one-cycle `upd_done` pulse. The two never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request, taken when `ready` is 1 |
| lk_idx | input | 7 | Word index of the lookup |
| lk_done | output | 1 | One-cycle pulse: lookup answer present |
| lk_valid | output | 1 | Lookup answer is valid |
| lk_data | output | 16 | Lookup answer word (0 when invalid) |
| upd_req | input | 1 | Checksum update request; a simultaneous lookup wins |
| upd_done | output | 1 | One-cycle pulse: checksum word written |
| ready | output | 1 | Block idle and able to take a request |
| sum_bad | output | 1 | Last load failed the checksum |
| sig_bad | output | 1 | Last load passed the checksum but failed the signature |
| mem_req | output | 1 | Request to the EEPROM master |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 6 | EEPROM word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge from the master |

## Verification
A lookup and a checksum update can be requested on the same edge. The bench provokes this by raising both requests together while the block is idle and then holding the update request until `ready` returns. The scoreboard queues the lookup answer ahead of the update completion and compares them in that order. This confirms that the lookup is served from the copy as it stood before the write. It also confirms that the held update still completes and makes the following lookup reload the image.

// File: rtl/eeshadow_pkg.sv
package eeshadow_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_EVAL  = 3'd2,
    ST_RESP  = 3'd3,
    ST_SUMRD = 3'd4,
    ST_WRITE = 3'd5
  } state_t;
endpackage

// File: rtl/eeshadow_sum.sv
// Wrapping accumulator shared by the load check and the checksum update.
module eeshadow_sum #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [DW-1:0] addend,
  output logic [DW-1:0] sum
);
  logic [DW-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clr)         sum_d = '0;
    else if (add_en) sum_d = sum_q + addend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum = sum_q;
endmodule

// File: rtl/eeshadow_store.sv
// Local word copy; entry 0 can have its signature field cleared.
module eeshadow_store #(
  parameter int            NWORDS    = 64,
  parameter int            DW        = 16,
  parameter int            AW        = 6,
  parameter logic [DW-1:0] SIG_MASK  = 16'hC000,
  parameter logic [DW-1:0] SIG_CLEAR = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          inv_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] head_word
);
  logic [NWORDS*DW-1:0] flat;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [DW-1:0] q, d;
    if (g == 0) begin : g_head
      always_comb begin
        d = q;
        if (wr_en && wr_addr == AW'(g)) d = wr_data;
        else if (inv_en)                d = (q & ~SIG_MASK) | (SIG_CLEAR & SIG_MASK);
      end
    end else begin : g_body
      always_comb begin
        d = q;
        if (wr_en && wr_addr == AW'(g)) d = wr_data;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign flat[g*DW +: DW] = q;
  end

  assign rd_data   = flat[rd_addr*DW +: DW];
  assign head_word = flat[DW-1:0];
endmodule

// File: rtl/eeshadow_ctrl.sv
module eeshadow_ctrl #(
  parameter int            NWORDS     = 64,
  parameter int            DW         = 16,
  parameter int            IDXW       = 7,
  parameter int            AW         = $clog2(NWORDS),
  parameter logic [DW-1:0] SUM_TARGET = 16'hBABA,
  parameter logic [DW-1:0] SIG_MASK   = 16'hC000,
  parameter logic [DW-1:0] SIG_VALID  = 16'h4000,
  parameter logic [DW-1:0] SIG_CLEAR  = 16'h0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_req,
  input  logic [IDXW-1:0] lk_idx,
  output logic            lk_done,
  output logic            lk_valid,
  output logic [DW-1:0]   lk_data,
  input  logic            upd_req,
  output logic            upd_done,
  output logic            ready,
  output logic            sum_bad,
  output logic            sig_bad,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack
);
  import eeshadow_pkg::*;

  localparam logic [AW-1:0]   LAST_W   = AW'(NWORDS - 1);
  localparam logic [AW-1:0]   LAST_SUM = AW'(NWORDS - 2);
  localparam logic [IDXW-1:0] IDX_LIM  = IDXW'(NWORDS);

  state_t          state_q, state_d;
  logic [AW-1:0]   cnt_q, cnt_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            lk_done_q, lk_done_d, upd_done_q, upd_done_d;
  logic            lk_valid_q, lk_valid_d;
  logic [DW-1:0]   lk_data_q, lk_data_d;
  logic            sum_bad_q, sum_bad_d, sig_bad_q, sig_bad_d;
  logic            acc_clr, acc_add, st_wr, st_inv;
  logic [DW-1:0]   acc_sum, st_rd, head;
  logic            sig_ok, idx_ok;

  eeshadow_sum #(.DW(DW)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add_en(acc_add),
    .addend(mem_rdata), .sum(acc_sum)
  );

  eeshadow_store #(
    .NWORDS(NWORDS), .DW(DW), .AW(AW), .SIG_MASK(SIG_MASK), .SIG_CLEAR(SIG_CLEAR)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(st_wr), .wr_addr(cnt_q), .wr_data(mem_rdata),
    .inv_en(st_inv), .rd_addr(idx_q[AW-1:0]), .rd_data(st_rd), .head_word(head)
  );

  assign sig_ok = (head & SIG_MASK) == SIG_VALID;
  assign idx_ok = idx_q < IDX_LIM;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    lk_done_d  = 1'b0;
    upd_done_d = 1'b0;
    lk_valid_d = lk_valid_q;
    lk_data_d  = lk_data_q;
    sum_bad_d  = sum_bad_q;
    sig_bad_d  = sig_bad_q;
    acc_clr    = 1'b0;
    acc_add    = 1'b0;
    st_wr      = 1'b0;
    st_inv     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (lk_req) begin
          idx_d = lk_idx;
          if (lk_idx >= IDX_LIM || sig_ok) begin
            state_d = ST_RESP;
          end else begin
            state_d = ST_LOAD;
            cnt_d   = '0;
            acc_clr = 1'b1;
          end
        end else if (upd_req) begin
          state_d = ST_SUMRD;
          cnt_d   = '0;
          acc_clr = 1'b1;
        end
      end
      ST_LOAD: begin
        if (mem_ack) begin
          st_wr   = 1'b1;
          acc_add = 1'b1;
          if (cnt_q == LAST_W) state_d = ST_EVAL;
          else                 cnt_d   = cnt_q + 1'b1;
        end
      end
      ST_EVAL: begin
        if (acc_sum != SUM_TARGET) begin
          st_inv    = 1'b1;
          sum_bad_d = 1'b1;
          sig_bad_d = 1'b0;
        end else begin
          sum_bad_d = 1'b0;
          sig_bad_d = !sig_ok;
        end
        state_d = ST_RESP;
      end
      ST_RESP: begin
        lk_done_d  = 1'b1;
        lk_valid_d = idx_ok && sig_ok;
        lk_data_d  = (idx_ok && sig_ok) ? st_rd : '0;
        state_d    = ST_IDLE;
      end
      ST_SUMRD: begin
        if (mem_ack) begin
          acc_add = 1'b1;
          if (cnt_q == LAST_SUM) state_d = ST_WRITE;
          else                   cnt_d   = cnt_q + 1'b1;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          st_inv     = 1'b1;
          upd_done_d = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      lk_done_q  <= 1'b0;
      upd_done_q <= 1'b0;
      lk_valid_q <= 1'b0;
      lk_data_q  <= '0;
      sum_bad_q  <= 1'b0;
      sig_bad_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      idx_q      <= idx_d;
      lk_done_q  <= lk_done_d;
      upd_done_q <= upd_done_d;
      lk_valid_q <= lk_valid_d;
      lk_data_q  <= lk_data_d;
      sum_bad_q  <= sum_bad_d;
      sig_bad_q  <= sig_bad_d;
    end
  end

  assign ready     = state_q == ST_IDLE;
  assign mem_req   = state_q == ST_LOAD || state_q == ST_SUMRD || state_q == ST_WRITE;
  assign mem_we    = state_q == ST_WRITE;
  assign mem_addr  = (state_q == ST_WRITE) ? LAST_W : cnt_q;
  assign mem_wdata = SUM_TARGET - acc_sum;
  assign lk_done   = lk_done_q;
  assign lk_valid  = lk_valid_q;
  assign lk_data   = lk_data_q;
  assign upd_done  = upd_done_q;
  assign sum_bad   = sum_bad_q;
  assign sig_bad   = sig_bad_q;
endmodule

// File: rtl/eeshadow_ctrl_chk.sv
module eeshadow_ctrl_chk #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          lk_done,
  input logic          lk_valid,
  input logic [DW-1:0] lk_data,
  input logic          upd_done,
  input logic          sum_bad,
  input logic          sig_bad
);
  // R9: no EEPROM traffic while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_req);

  // R2: request held with stable address until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R2, R7: consecutive reads step the address by one
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $past(mem_req) && $past(mem_ack) && !$past(mem_we))
      |-> (mem_addr - $past(mem_addr)) == AW'(1));

  // R7: the only write goes to the last word
  p_write_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_addr == {AW{1'b1}});

  // R6: an invalid answer carries zero data
  p_zero_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && !lk_valid) |-> lk_data == '0);

  // R4: the two failure flags exclude each other
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sum_bad && sig_bad));

  // R10: completion pulses never coincide and last one cycle
  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_done, upd_done}));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |=> !lk_done);
endmodule

bind eeshadow_ctrl eeshadow_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/eeshadow_ctrl_tb.sv
module eeshadow_ctrl_tb;
  localparam logic [15:0] TGT   = 16'hBABA;
  localparam logic [15:0] MASK  = 16'hC000;
  localparam logic [15:0] VALID = 16'h4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req = 1'b0, upd_req = 1'b0;
  logic [6:0] lk_idx = '0;
  logic lk_done, lk_valid, upd_done, ready, sum_bad, sig_bad;
  logic [15:0] lk_data;
  logic mem_req, mem_we, mem_ack;
  logic [5:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  eeshadow_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_idx(lk_idx),
    .lk_done(lk_done), .lk_valid(lk_valid), .lk_data(lk_data),
    .upd_req(upd_req), .upd_done(upd_done), .ready(ready),
    .sum_bad(sum_bad), .sig_bad(sig_bad), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // EEPROM master model with a one-cycle acknowledge
  logic [15:0] ee [64];
  int rd_cnt = 0, wr_cnt = 0;
  logic poke_en = 1'b0;
  logic [5:0] poke_addr = '0;
  logic [15:0] poke_val = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      if (poke_en) ee[poke_addr] <= poke_val;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          ee[mem_addr] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata <= ee[mem_addr];
          rd_cnt <= rd_cnt + 1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    bit          is_upd;
    bit          valid;
    logic [15:0] data;
    string       req;
  } item_t;
  item_t exp_q[$];

  // Monitor: compare completions in order
  always @(negedge clk) begin
    if (rst_n && (lk_done || upd_done)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected completion", {30'd0, upd_done, lk_done}, 32'd0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(upd_done == it.is_upd, {it.req, " kind"}, {31'd0, upd_done}, {31'd0, it.is_upd});
        if (!it.is_upd) begin
          check(lk_valid == it.valid, {it.req, " valid"}, {31'd0, lk_valid}, {31'd0, it.valid});
          check(lk_data == it.data, {it.req, " data"}, {16'd0, lk_data}, {16'd0, it.data});
        end
      end
    end
  end

  // Reference copy of the cache
  logic [15:0] sh [64];
  bit sh_ok = 0, e_sum = 0, e_sig = 0;

  task automatic poke(input int a, input logic [15:0] v);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = 6'(a); poke_val = v;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  function automatic item_t predict_lookup(input int idx, input string req, output bit loaded);
    item_t it;
    logic [15:0] s;
    it.is_upd = 0; it.req = req; loaded = 0;
    if (idx >= 64) begin
      it.valid = 0; it.data = '0;
    end else if (sh_ok) begin
      it.valid = 1; it.data = sh[idx];
    end else begin
      loaded = 1; s = '0;
      for (int i = 0; i < 64; i++) begin sh[i] = ee[i]; s = s + ee[i]; end
      if (s != TGT) begin e_sum = 1; e_sig = 0; sh_ok = 0; end
      else begin e_sum = 0; e_sig = ((sh[0] & MASK) != VALID); sh_ok = !e_sig; end
      it.valid = sh_ok; it.data = sh_ok ? sh[idx] : 16'h0;
    end
    return it;
  endfunction

  task automatic lookup(input int idx, input string req);
    int r0; bit loaded; item_t it;
    @(negedge clk);
    while (!ready) @(negedge clk);
    r0 = rd_cnt;
    it = predict_lookup(idx, req, loaded);
    exp_q.push_back(it);
    lk_req = 1'b1; lk_idx = 7'(idx);
    @(negedge clk);
    lk_req = 1'b0;
    wait_drain();
    check(rd_cnt - r0 == (loaded ? 64 : 0), {req, " read count"}, rd_cnt - r0, loaded ? 64 : 0);
    if (loaded) begin
      check(sum_bad == e_sum, {req, " sum_bad"}, {31'd0, sum_bad}, {31'd0, e_sum});
      check(sig_bad == e_sig, {req, " sig_bad"}, {31'd0, sig_bad}, {31'd0, e_sig});
    end
  endtask

  function automatic logic [15:0] expect_fix();
    logic [15:0] s = '0;
    for (int i = 0; i < 63; i++) s = s + ee[i];
    return TGT - s;
  endfunction

  task automatic update(input string req);
    int r0, w0; logic [15:0] ev; item_t it;
    @(negedge clk);
    while (!ready) @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt; ev = expect_fix();
    it.is_upd = 1; it.valid = 0; it.data = '0; it.req = req;
    exp_q.push_back(it);
    upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
    wait_drain();
    sh_ok = 0;
    check(ee[63] == ev, {req, " word63"}, {16'd0, ee[63]}, {16'd0, ev});
    check(rd_cnt - r0 == 63, {req, " reads"}, rd_cnt - r0, 63);
    check(wr_cnt - w0 == 1, {req, " writes"}, wr_cnt - w0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    // build a valid image; raw sum wraps past 16 bits (R3)
    s = '0;
    for (int i = 0; i < 63; i++) begin
      ee[i] = 16'(i * 16'h0B37 + 16'h1F05);
      if (i == 0) ee[i] = (ee[i] & ~MASK) | VALID;
      s = s + ee[i];
    end
    ee[63] = TGT - s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ready == 1'b1, "R1 ready", {31'd0, ready}, 1);
    check(mem_req == 1'b0, "R1 mem_req", {31'd0, mem_req}, 0);
    check({lk_done, upd_done, sum_bad, sig_bad} == 4'b0, "R1 outputs",
          {28'd0, lk_done, upd_done, sum_bad, sig_bad}, 0);

    lookup(64, "R6 index 64");
    lookup(127, "R6 index 127");
    lookup(5, "R1 R2 R3 first load");
    lookup(63, "R5 cached last");
    poke(7, 16'hDEAD);
    lookup(7, "R5 stale eeprom");
    update("R7 update");
    lookup(7, "R8 reload after write");

    // R3 checksum failure
    poke(20, ee[20] + 16'h0001);
    lookup(20, "R3 bad sum");
    lookup(1, "R3 reload after fail");

    // R4 signature failure with repaired checksum
    poke(0, (ee[0] & ~MASK) | 16'h8000);
    update("R7 update sig");
    lookup(0, "R4 bad sig");
    lookup(2, "R4 reload after sig fail");

    poke(0, (ee[0] & ~MASK) | VALID);
    update("R7 update restore");
    lookup(0, "R4 both pass");

    // R9 simultaneous lookup and update
    begin
      bit loaded; item_t it, iu; int w0;
      @(negedge clk);
      while (!ready) @(negedge clk);
      w0 = wr_cnt;
      it = predict_lookup(3, "R9 lookup first", loaded);
      exp_q.push_back(it);
      iu.is_upd = 1; iu.valid = 0; iu.data = '0; iu.req = "R9 update second";
      exp_q.push_back(iu);
      lk_req = 1'b1; lk_idx = 7'd3; upd_req = 1'b1;
      @(negedge clk);
      lk_req = 1'b0;
      check(wr_cnt == w0 && !ready, "R9 held off", {31'd0, ready}, 0);
      while (!ready) @(negedge clk);
      @(negedge clk);
      upd_req = 1'b0;
      wait_drain();
      sh_ok = 0;
      check(wr_cnt - w0 == 1, "R9 update done", wr_cnt - w0, 1);
    end
    lookup(3, "R8 reload after simultaneous");

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule